// File: doc/BRIEF.md
# Parallel Display Bus Strobe Timer

This block produces the chip-select, write-strobe and read-strobe signals for one access on an asynchronous parallel display bus. It also latches read data at a programmed sample point. Two configuration words set the timing. Each strobe gets its own assert tick and release tick, counted from the start of the access. The words also give a cycle length for writes, a cycle length for reads, a read sample tick and a minimum chip-select idle gap. A granularity input selects the tick length: one core clock, or two core clocks.

A requester raises `reqValid` together with the direction, the command/data flag and the write word. The request is taken in the cycle where `reqAccept` is high. The first clock after that cycle is the first clock of tick 0. The block also checks the programmed values against the ordering rules every cycle. If any rule fails, `cfgValid` drops and no request is taken. When the access ends, `done` pulses, and chip-select then stays released for the programmed gap before the next request can be taken. The polarity of each pin is chosen separately.

Top module: `pbus_strobe_timer`

## Requirements
- R1: Field positions. `onOffWord` holds CS assert [3:0], CS release [9:4], WE assert [13:10], WE release [19:14], RE assert [23:20] and RE release [29:24]. A strobe is active on every clock whose tick t satisfies assert ≤ t < release. Tick 0 starts on the first clock after the accept cycle.
- R2: When `halfRate` is 1, each tick lasts two clocks. When it is 0, each tick lasts one clock.
- R3: `cycleWord` holds the write cycle in [5:0] and the read cycle in [11:6]. An access lasts (cycle+1) ticks, using the cycle value for its direction. `done` is high for exactly one clock, the last clock of the access. No new request is taken while an access runs.
- R4: In a read, `rdData` captures `rdBusIn` on the first clock of the tick equal to the access time. The access time is held in `cycleWord` [27:22].
- R5: After `done`, CS stays inactive and `reqAccept` stays low for (CS gap × tick length) clocks. The CS gap is held in `cycleWord` [17:12]. A gap of 0 adds no wait.
- R6: `cfgValid` is 1 only when all of these hold:
  - WE release > WE assert
  - RE release > RE assert
  - CS release > CS assert
  - CS release ≥ WE release, and CS release ≥ RE release
  - access time > RE assert
  - access time ≤ read cycle
  - write cycle ≥ WE release, and read cycle ≥ RE release
  - `cycleWord` [21:18] is zero

  While `cfgValid` is 0, `reqAccept` stays 0 and no strobe is driven.
- R7: `csHigh`, `weHigh`, `reHigh` and `a0High` each set the active level of one pin. A value of 0 means active low, and an inactive pin sits at the opposite level. After reset, every strobe pin is inactive.
- R8: The A0 pin is active during an access only when `reqCmd` was 1 at acceptance, and it is inactive outside accesses. During a write, `busOe` is 1 and `busData` holds the accepted word from tick 0 until `done`. A0 stays stable over the same span.
- R9: WE is never active during a read, and RE is never active during a write. `busOe` is 0 during reads and while idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rstN | input | 1 | Active-low synchronous reset |
| onOffWord | input | 30 | Assert and release ticks of the three strobes |
| cycleWord | input | 28 | Cycle lengths, CS gap and read sample tick |
| halfRate | input | 1 | 1 makes each tick two clocks long |
| csHigh | input | 1 | CS active level |
| weHigh | input | 1 | WE active level |
| reHigh | input | 1 | RE active level |
| a0High | input | 1 | A0 active level |
| reqValid | input | 1 | Access request |
| reqRead | input | 1 | 1 for a read access, 0 for a write access |
| reqCmd | input | 1 | 1 makes A0 active for the access |
| reqWrData | input | DATA_W | Write word |
| rdBusIn | input | DATA_W | Bus data for reads |
| reqAccept | output | 1 | Request taken this cycle |
| cfgValid | output | 1 | Timing words obey the ordering rules |
| done | output | 1 | One-clock pulse on the last clock of an access |
| csPin | output | 1 | Chip select |
| wePin | output | 1 | Write strobe |
| rePin | output | 1 | Read strobe |
| a0Pin | output | 1 | Command/data select |
| busOe | output | 1 | Drive enable for write data |
| busData | output | DATA_W | Held write word |
| rdData | output | DATA_W | Captured read word |

## Verification
The bench builds the block with its default 16-bit data width; the tick fields are fixed by the word layout. A vector table sweeps both tick lengths, both directions and strobe windows that run up to the largest field values. Those vectors include a 63-tick write cycle and an assert tick of 15. The bench predicts the level of every pin on every clock from the field values. Directed tests then cover the CS gap at both tick lengths, inverted polarities and each ordering rule broken in turn.

// File: rtl/pbus_timer_pkg.sv
package pbus_timer_pkg;
  localparam int ON_W    = 4;
  localparam int OFF_W   = 6;
  localparam int ONOFF_W = 3 * (ON_W + OFF_W);
  localparam int CYC_W   = 28;

  typedef struct packed {
    logic [ON_W-1:0]  csOn;
    logic [ON_W-1:0]  weOn;
    logic [ON_W-1:0]  reOn;
    logic [OFF_W-1:0] csOff;
    logic [OFF_W-1:0] weOff;
    logic [OFF_W-1:0] reOff;
    logic [OFF_W-1:0] weCyc;
    logic [OFF_W-1:0] reCyc;
    logic [OFF_W-1:0] csGap;
    logic [OFF_W-1:0] accTime;
  } timing_t;

  // Control-to-datapath strobes
  typedef struct packed {
    logic load;
    logic active;
    logic isRead;
    logic csAct;
    logic weAct;
    logic reAct;
    logic sample;
  } strobe_t;

  function automatic logic [OFF_W-1:0] widenOn(input logic [ON_W-1:0] v);
    return {{(OFF_W-ON_W){1'b0}}, v};
  endfunction
endpackage

// File: rtl/pbus_timing_check.sv
module pbus_timing_check
  import pbus_timer_pkg::*;
(
  input  logic [ONOFF_W-1:0] onOffWord,
  input  logic [CYC_W-1:0]   cycleWord,
  output timing_t            tim,
  output logic               cfgOk
);
  always_comb begin
    tim.csOn    = onOffWord[3:0];
    tim.csOff   = onOffWord[9:4];
    tim.weOn    = onOffWord[13:10];
    tim.weOff   = onOffWord[19:14];
    tim.reOn    = onOffWord[23:20];
    tim.reOff   = onOffWord[29:24];
    tim.weCyc   = cycleWord[5:0];
    tim.reCyc   = cycleWord[11:6];
    tim.csGap   = cycleWord[17:12];
    tim.accTime = cycleWord[27:22];
  end

  assign cfgOk = (tim.weOff > widenOn(tim.weOn))
              && (tim.reOff > widenOn(tim.reOn))
              && (tim.csOff > widenOn(tim.csOn))
              && (tim.csOff >= tim.weOff)
              && (tim.csOff >= tim.reOff)
              && (tim.accTime > widenOn(tim.reOn))
              && (tim.accTime <= tim.reCyc)
              && (tim.weCyc >= tim.weOff)
              && (tim.reCyc >= tim.reOff)
              && (cycleWord[21:18] == 4'd0);
endmodule

// File: rtl/pbus_timer_ctrl.sv
module pbus_timer_ctrl
  import pbus_timer_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  timing_t tim,
  input  logic    cfgOk,
  input  logic    halfRate,
  input  logic    reqValid,
  input  logic    reqRead,
  output logic    reqAccept,
  output logic    done,
  output strobe_t stb
);
  typedef enum logic [1:0] {S_IDLE, S_ACT, S_GAP} state_e;

  state_e           state;
  logic [OFF_W-1:0] tick;
  logic             sub;
  logic             isRead;
  logic             tickStep;
  logic             lastTick;
  logic             gapEnd;
  logic [OFF_W-1:0] cycEnd;

  assign tickStep  = !halfRate || sub;
  assign cycEnd    = isRead ? tim.reCyc : tim.weCyc;
  assign lastTick  = (tick == cycEnd);
  assign gapEnd    = (tick == (tim.csGap - OFF_W'(1)));
  assign reqAccept = (state == S_IDLE) && reqValid && cfgOk;
  assign done      = (state == S_ACT) && lastTick && tickStep;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state  <= S_IDLE;
      tick   <= '0;
      sub    <= 1'b0;
      isRead <= 1'b0;
    end else begin
      case (state)
        S_IDLE: begin
          sub <= 1'b0;
          if (reqAccept) begin
            state  <= S_ACT;
            tick   <= '0;
            isRead <= reqRead;
          end
        end
        S_ACT: begin
          sub <= !tickStep;
          if (tickStep) begin
            if (lastTick) begin
              tick  <= '0;
              state <= (tim.csGap != '0) ? S_GAP : S_IDLE;
            end else begin
              tick <= tick + OFF_W'(1);
            end
          end
        end
        default: begin
          sub <= !tickStep;
          if (tickStep) begin
            if (gapEnd) begin
              tick  <= '0;
              state <= S_IDLE;
            end else begin
              tick <= tick + OFF_W'(1);
            end
          end
        end
      endcase
    end
  end

  logic act;
  assign act = (state == S_ACT);

  always_comb begin
    stb.load   = reqAccept;
    stb.active = act;
    stb.isRead = isRead;
    stb.csAct  = act && (tick >= widenOn(tim.csOn)) && (tick < tim.csOff);
    stb.weAct  = act && !isRead && (tick >= widenOn(tim.weOn)) && (tick < tim.weOff);
    stb.reAct  = act && isRead && (tick >= widenOn(tim.reOn)) && (tick < tim.reOff);
    stb.sample = act && isRead && (tick == tim.accTime) && !sub;
  end
endmodule

// File: rtl/pbus_timer_dpath.sv
module pbus_timer_dpath
  import pbus_timer_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           stb,
  input  logic              reqCmd,
  input  logic [DATA_W-1:0] reqWrData,
  input  logic [DATA_W-1:0] rdBusIn,
  input  logic              csHigh,
  input  logic              weHigh,
  input  logic              reHigh,
  input  logic              a0High,
  output logic              csPin,
  output logic              wePin,
  output logic              rePin,
  output logic              a0Pin,
  output logic              busOe,
  output logic [DATA_W-1:0] busData,
  output logic [DATA_W-1:0] rdData
);
  logic              cmdReg;
  logic [DATA_W-1:0] wrReg;
  logic [DATA_W-1:0] rdReg;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cmdReg <= 1'b0;
      wrReg  <= '0;
      rdReg  <= '0;
    end else begin
      if (stb.load) begin
        cmdReg <= reqCmd;
        wrReg  <= reqWrData;
      end
      if (stb.sample) rdReg <= rdBusIn;
    end
  end

  // Active level equals the polarity bit; inactive is its complement
  assign csPin   = ~(stb.csAct ^ csHigh);
  assign wePin   = ~(stb.weAct ^ weHigh);
  assign rePin   = ~(stb.reAct ^ reHigh);
  assign a0Pin   = ~((stb.active & cmdReg) ^ a0High);
  assign busOe   = stb.active & ~stb.isRead;
  assign busData = wrReg;
  assign rdData  = rdReg;
endmodule

// File: rtl/pbus_strobe_timer.sv
module pbus_strobe_timer
  import pbus_timer_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [29:0]       onOffWord,
  input  logic [27:0]       cycleWord,
  input  logic              halfRate,
  input  logic              csHigh,
  input  logic              weHigh,
  input  logic              reHigh,
  input  logic              a0High,
  input  logic              reqValid,
  input  logic              reqRead,
  input  logic              reqCmd,
  input  logic [DATA_W-1:0] reqWrData,
  input  logic [DATA_W-1:0] rdBusIn,
  output logic              reqAccept,
  output logic              cfgValid,
  output logic              done,
  output logic              csPin,
  output logic              wePin,
  output logic              rePin,
  output logic              a0Pin,
  output logic              busOe,
  output logic [DATA_W-1:0] busData,
  output logic [DATA_W-1:0] rdData
);
  timing_t tim;
  strobe_t stb;

  pbus_timing_check u_check (
    .onOffWord(onOffWord), .cycleWord(cycleWord), .tim(tim), .cfgOk(cfgValid)
  );

  pbus_timer_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .tim(tim), .cfgOk(cfgValid), .halfRate(halfRate),
    .reqValid(reqValid), .reqRead(reqRead), .reqAccept(reqAccept),
    .done(done), .stb(stb)
  );

  pbus_timer_dpath #(.DATA_W(DATA_W)) u_dpath (
    .clk(clk), .rstN(rstN), .stb(stb), .reqCmd(reqCmd), .reqWrData(reqWrData),
    .rdBusIn(rdBusIn), .csHigh(csHigh), .weHigh(weHigh), .reHigh(reHigh),
    .a0High(a0High), .csPin(csPin), .wePin(wePin), .rePin(rePin),
    .a0Pin(a0Pin), .busOe(busOe), .busData(busData), .rdData(rdData)
  );
endmodule

// File: rtl/pbus_strobe_timer_chk.sv
module pbus_strobe_timer_chk #(
  parameter int DATA_W = 16
) (
  input logic              clk,
  input logic              rstN,
  input logic              cfgValid,
  input logic              reqAccept,
  input logic              done,
  input logic              csPin,
  input logic              wePin,
  input logic              rePin,
  input logic              a0Pin,
  input logic              busOe,
  input logic [DATA_W-1:0] busData,
  input logic              csHigh,
  input logic              weHigh,
  input logic              reHigh
);
  assert_refuse_invalid_R6: assert property (@(posedge clk) disable iff (!rstN)
    !cfgValid |-> !reqAccept);

  assert_done_single_R3: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  assert_no_accept_busy_R3: assert property (@(posedge clk) disable iff (!rstN)
    reqAccept |=> !reqAccept);

  assert_write_hold_R8: assert property (@(posedge clk) disable iff (!rstN)
    (busOe && !done) |=> (busOe && $stable(busData) && $stable(a0Pin)));

  assert_cs_release_R5: assert property (@(posedge clk) disable iff (!rstN)
    done |=> (csPin != csHigh));

  assert_no_re_in_write_R9: assert property (@(posedge clk) disable iff (!rstN)
    busOe |-> (rePin != reHigh));

  assert_no_we_in_read_R9: assert property (@(posedge clk) disable iff (!rstN)
    (rePin == reHigh) |-> ((wePin != weHigh) && !busOe));
endmodule

bind pbus_strobe_timer pbus_strobe_timer_chk #(.DATA_W(DATA_W)) u_chk (
  .clk(clk), .rstN(rstN), .cfgValid(cfgValid), .reqAccept(reqAccept),
  .done(done), .csPin(csPin), .wePin(wePin), .rePin(rePin), .a0Pin(a0Pin),
  .busOe(busOe), .busData(busData), .csHigh(csHigh), .weHigh(weHigh),
  .reHigh(reHigh)
);

// File: tb/pbus_strobe_timer_tb.sv
module pbus_strobe_timer_tb;
  localparam int DW = 16;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [29:0] onOffWord = '0;
  logic [27:0] cycleWord = '0;
  logic halfRate = 1'b0;
  logic csHigh = 1'b0, weHigh = 1'b0, reHigh = 1'b0, a0High = 1'b0;
  logic reqValid = 1'b0, reqRead = 1'b0, reqCmd = 1'b0;
  logic [DW-1:0] reqWrData = '0, rdBusIn = '0;
  logic reqAccept, cfgValid, done, csPin, wePin, rePin, a0Pin, busOe;
  logic [DW-1:0] busData, rdData;

  always #10 clk = ~clk;

  pbus_strobe_timer #(.DATA_W(DW)) u_dut (.*);

  int nChk = 0, nFail = 0;
  int csOn, csOff, weOn, weOff, reOn, reOff, weCyc, reCyc, csPw, accT;
  bit resvBad = 0;

  // vector: half,rd,csOn4,csOff6,weOn4,weOff6,reOn4,reOff6,weCyc6,reCyc6,csPw6,acc6
  localparam logic [55:0] VEC [6] = '{
    {1'b0,1'b0,4'd0, 6'd5, 4'd1, 6'd4, 4'd1,6'd3,6'd6, 6'd5, 6'd2,6'd2},
    {1'b0,1'b1,4'd0, 6'd5, 4'd1, 6'd4, 4'd1,6'd3,6'd6, 6'd5, 6'd2,6'd2},
    {1'b1,1'b0,4'd0, 6'd5, 4'd1, 6'd4, 4'd1,6'd3,6'd6, 6'd5, 6'd2,6'd2},
    {1'b1,1'b1,4'd0, 6'd6, 4'd1, 6'd4, 4'd2,6'd5,6'd6, 6'd7, 6'd2,6'd4},
    {1'b0,1'b1,4'd2, 6'd9, 4'd3, 6'd7, 4'd3,6'd9,6'd8, 6'd12,6'd1,6'd8},
    {1'b0,1'b0,4'd15,6'd63,4'd15,6'd62,4'd0,6'd1,6'd63,6'd1, 6'd0,6'd1}
  };

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    nChk++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic applyCfg();
    onOffWord = {6'(reOff), 4'(reOn), 6'(weOff), 4'(weOn), 6'(csOff), 4'(csOn)};
    cycleWord = {6'(accT), (resvBad ? 4'b0100 : 4'b0000), 6'(csPw), 6'(reCyc), 6'(weCyc)};
  endtask

  function automatic logic lvl(input bit act, input logic hi);
    return act ? hi : ~hi;
  endfunction

  // Runs one access; predicts every pin on every clock (R1 R2 R3 R4 R8 R9)
  task automatic runAccess(input bit rd, input bit cmd, input logic [DW-1:0] wd,
                           input string tag);
    int len, cyc, total, eCs, eWe, eRe, eDone, eA0, eBus;
    len = halfRate ? 2 : 1;
    cyc = rd ? reCyc : weCyc;
    total = (cyc + 1) * len;
    eCs = 0; eWe = 0; eRe = 0; eDone = 0; eA0 = 0; eBus = 0;
    @(negedge clk);
    reqValid = 1'b1; reqRead = rd; reqCmd = cmd; reqWrData = wd;
    #1 chk(reqAccept === 1'b1, "R6", {tag, " accept with valid timing"}, int'(reqAccept), 1);
    @(negedge clk);
    reqValid = 1'b0; reqWrData = ~wd;
    for (int k = 0; k < total; k++) begin
      int tk;
      tk = k / len;
      if (csPin !== lvl(tk >= csOn && tk < csOff, csHigh)) eCs++;
      if (wePin !== lvl(!rd && tk >= weOn && tk < weOff, weHigh)) eWe++;
      if (rePin !== lvl(rd && tk >= reOn && tk < reOff, reHigh)) eRe++;
      if (done !== (k == total - 1)) eDone++;
      if (a0Pin !== lvl(cmd, a0High)) eA0++;
      if (busOe !== !rd || (!rd && busData !== wd)) eBus++;
      rdBusIn = 16'hC000 + 16'(k);
      @(negedge clk);
    end
    chk(eCs == 0, "R1", {tag, " CS window mismatches"}, eCs, 0);
    chk(eWe == 0, "R9", {tag, " WE window mismatches"}, eWe, 0);
    chk(eRe == 0, "R1", {tag, " RE window mismatches"}, eRe, 0);
    chk(eDone == 0, "R3", {tag, " done timing mismatches"}, eDone, 0);
    chk(eA0 == 0, "R8", {tag, " A0 mismatches"}, eA0, 0);
    chk(eBus == 0, "R8", {tag, " write bus mismatches"}, eBus, 0);
    if (rd)
      chk(rdData === 16'hC000 + 16'(accT * len), "R4", {tag, " read sample"},
          int'(rdData), 16'hC000 + accT * len);
    chk(csPin === lvl(0, csHigh) && busOe === 1'b0, "R5", {tag, " released after done"},
        int'(csPin), int'(lvl(0, csHigh)));
  endtask

  // Counts clocks of refusal after an access before the next accept (R5)
  task automatic gapTest(input string tag);
    int waits;
    runAccess(1'b0, 1'b0, 16'h5A5A, tag);
    reqValid = 1'b1; reqRead = 1'b0;
    waits = 0;
    #1;
    while (reqAccept !== 1'b1 && waits < 300) begin
      @(negedge clk); #1; waits++;
    end
    chk(waits == csPw * (halfRate ? 2 : 1), "R5", {tag, " gap clocks"}, waits,
        csPw * (halfRate ? 2 : 1));
    @(negedge clk); reqValid = 1'b0;
    repeat (140) @(negedge clk);
  endtask

  task automatic loadVec(input int i);
    logic [55:0] v;
    v = VEC[i];
    halfRate = v[55];
    csOn = v[53:50]; csOff = v[49:44]; weOn = v[43:40]; weOff = v[39:34];
    reOn = v[33:30]; reOff = v[29:24]; weCyc = v[23:18]; reCyc = v[17:12];
    csPw = v[11:6]; accT = v[5:0];
    applyCfg();
  endtask

  task automatic badCfg(input string what);
    applyCfg();
    @(negedge clk);
    reqValid = 1'b1;
    #1 chk(cfgValid === 1'b0 && reqAccept === 1'b0, "R6", what, int'(reqAccept), 0);
    @(negedge clk);
    chk(csPin === lvl(0, csHigh), "R6", {what, " no strobe"}, int'(csPin), int'(lvl(0, csHigh)));
    reqValid = 1'b0;
    loadVec(0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nChk++; nFail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", nChk - nFail, nChk);
    $finish;
  end

  initial begin
    loadVec(0);
    repeat (3) @(negedge clk);
    // reset state (R7)
    chk(csPin === 1'b1 && wePin === 1'b1 && rePin === 1'b1 && a0Pin === 1'b1, "R7",
        "pins inactive in reset", int'({csPin, wePin, rePin, a0Pin}), 15);
    chk(done === 1'b0 && busOe === 1'b0, "R9", "no done/drive in reset", int'(done), 0);
    rstN = 1'b1;
    @(negedge clk);

    // table walk (R1 R2 R3 R4 R8 R9)
    for (int i = 0; i < 6; i++) begin
      loadVec(i);
      runAccess(VEC[i][54], i[0], 16'h1234 + 16'(i), $sformatf("vec%0d", i));
      repeat (140) @(negedge clk);
    end

    // CS gap at both tick lengths (R5, R2)
    loadVec(0); gapTest("gap full-rate");
    loadVec(2); gapTest("gap half-rate");

    // polarity inverted (R7)
    loadVec(1);
    csHigh = 1'b1; weHigh = 1'b1; reHigh = 1'b1; a0High = 1'b1;
    @(negedge clk);
    chk(csPin === 1'b0 && rePin === 1'b0 && a0Pin === 1'b0, "R7",
        "idle levels with high polarity", int'({csPin, rePin, a0Pin}), 0);
    runAccess(1'b1, 1'b1, 16'h0F0F, "R7 active-high read");
    repeat (140) @(negedge clk);
    loadVec(0);
    runAccess(1'b0, 1'b1, 16'hBEEF, "R7 active-high write");
    repeat (140) @(negedge clk);
    csHigh = 1'b0; weHigh = 1'b0; reHigh = 1'b0; a0High = 1'b0;

    // ordering rules (R6)
    loadVec(0); weOff = weOn;      badCfg("R6 WE release equals assert");
    reOff = reOn;                  badCfg("R6 RE release equals assert");
    csOff = 3;                     badCfg("R6 CS release below WE release");
    accT = reOn;                   badCfg("R6 access time at RE assert");
    accT = reCyc + 1;              badCfg("R6 access time past read cycle");
    weCyc = weOff - 1;             badCfg("R6 write cycle below WE release");
    reCyc = reOff - 1;             badCfg("R6 read cycle below RE release");
    resvBad = 1;                   badCfg("R6 reserved bits set");
    resvBad = 0;
    loadVec(0);
    @(negedge clk);
    chk(cfgValid === 1'b1, "R6", "restored timing valid", int'(cfgValid), 1);

    $display("%0d/%0d checks passed", nChk - nFail, nChk);
    $finish;
  end
endmodule